// File: doc/BRIEF.md
# Status register write unit

This block executes the move-to-status-register operation of a 32-bit processor pipeline. Each cycle it decodes the presented instruction word. When the word is a register-source or immediate-source status write and the condition-passed input is high, it merges the selected byte lanes of the source value into the current status register (CPSR) or the saved status register (SPSR). The merge obeys the privilege rules of the current processor mode.

Both registers are held inside the block and are visible on its outputs. Two one-cycle flags report rejected operations: a saved-register write attempted from a mode that has no saved register, and a current-register write that would place an illegal value in the mode field. The mode input gives the pipeline's view of the active mode and is used for all privilege decisions. The banked-register variant of the instruction is recognised as its own form and never changes either register. Updates happen on the rising clock edge.

Top module: `psr_write_unit`

## Requirements
- R1: A register-source write decodes when word bits [27:23]=00010, [21:20]=10, [15:12]=1111 and [11:4]=0. In a privileged mode it loads the selected lanes of `src_val` into CPSR at the next rising edge.
- R2: An immediate-source write decodes when bits [27:23]=00110, [21:20]=10 and [15:12]=1111. Its source is word bits [7:0] zero-extended to 32 bits, and `src_val` is ignored.
- R3: Word bit 22 picks the destination: 0 selects CPSR and 1 selects SPSR.
- R4: Mask bits [19:16] enable byte lanes: bit 16 enables [7:0], bit 17 enables [15:8], bit 18 enables [23:16] and bit 19 enables [31:24]. Lanes that are not enabled keep their value.
- R5: A word with bits [11:9]=001 and the other register-form fields set (the banked-register form) changes no state and raises no flag. Any other undecoded word also changes no state and raises no flag.
- R6: While `cond_ok` is 0, neither register changes and both flags stay 0.
- R7: A saved-register write while `cur_mode` is 10000 (user) or 11111 (system) leaves SPSR unchanged and sets `unpred_o` for one cycle. The same write in any other mode is performed.
- R8: The legal modes are 10000, 10001, 10010, 10011, 10111, 11011 and 11111. A CPSR write with lane 0 enabled whose new bits [4:0] are not legal keeps the old mode bits and sets `illegal_mode_o` for one cycle. The other enabled bits, including bits [7:5], are still written.
- R9: In user mode a CPSR write changes only lane [31:24] and the endianness bit 9. Bit 9 is written when mask bit 17 is set. All other lanes are protected.
- R10: Synchronous active-low reset sets CPSR to 0x00000013, SPSR to 0 and both flags to 0.
- R11: Each flag reflects only the instruction sampled at the preceding edge and returns to 0 on the following edge unless it is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_word | input | 32 | Instruction word to decode |
| cond_ok | input | 1 | Condition check passed for this word |
| src_val | input | 32 | Source general-purpose register value |
| cur_mode | input | 5 | Active processor mode |
| cpsr_q | output | 32 | Current status register |
| spsr_q | output | 32 | Saved status register |
| unpred_o | output | 1 | Saved-register write rejected in the previous cycle |
| illegal_mode_o | output | 1 | Illegal mode value rejected in the previous cycle |

## Verification
Mode rejection and lane merging can happen on the same edge. One CPSR write can carry an illegal mode value in lane 0 and a new flag byte in lane 3. The bench provokes this with mask 1001 and mode bits 10101 from the abort mode. It passes only if the top byte and bits [7:5] take the new value, the mode bits keep their old value and `illegal_mode_o` is high for exactly that cycle. The user-mode endianness write is a second coincidence, because a protected lane holds an unprotected bit. It is judged by bit 9 changing while the rest of its lane stays fixed.

// File: rtl/psr_pkg.sv
// Package: shared types and mode helpers for the status register write unit.
// Assumes a 32-bit status word with the mode field in [4:0] and endianness in bit 9.
package psr_pkg;
    localparam int unsigned PSR_W    = 32;
    localparam int unsigned MODE_W   = 5;
    localparam int unsigned E_BIT    = 9;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    typedef enum logic [1:0] {
        FORM_NONE   = 2'd0,
        FORM_REG    = 2'd1,
        FORM_IMM    = 2'd2,
        FORM_BANKED = 2'd3
    } form_e;

    // True when the mode encoding is one the block accepts.
    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        return (m == MODE_USR) || (m == MODE_FIQ) || (m == MODE_IRQ) ||
               (m == MODE_SVC) || (m == MODE_ABT) || (m == MODE_UND) ||
               (m == MODE_SYS);
    endfunction
endpackage

// File: rtl/psr_decode.sv
// Module: classifies an instruction word into register, immediate or banked
// status-write forms and extracts destination, lane mask and immediate source.
// Assumes the condition field is judged outside and arrives as a separate flag.
module psr_decode #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANES  = DATA_W / 8
) (
    input  logic [31:0]        instr,
    output psr_pkg::form_e     form,
    output logic               to_spsr,
    output logic [LANES-1:0]   lane_mask,
    output logic [DATA_W-1:0]  imm_val
);
    logic common_ok;
    logic reg_shape;
    logic bank_shape;
    logic imm_shape;

    // Field checks shared by every form, then per-form shape tests.
    always_comb begin
        common_ok  = (instr[21:20] == 2'b10) && (instr[15:12] == 4'hF);
        reg_shape  = (instr[27:23] == 5'b00010) && (instr[11:4] == 8'h00);
        bank_shape = (instr[27:23] == 5'b00010) && (instr[11:9] == 3'b001) &&
                     (instr[7:4] == 4'h0);
        imm_shape  = (instr[27:23] == 5'b00110);
    end

    // Form selection; banked is kept apart so it never reaches a write path.
    always_comb begin
        form = psr_pkg::FORM_NONE;
        if (common_ok) begin
            if (reg_shape)       form = psr_pkg::FORM_REG;
            else if (bank_shape) form = psr_pkg::FORM_BANKED;
            else if (imm_shape)  form = psr_pkg::FORM_IMM;
        end
    end

    // Operand fields: destination select, lane mask, unrotated immediate.
    always_comb begin
        to_spsr   = instr[22];
        lane_mask = instr[16 +: LANES];
        imm_val   = {{(DATA_W-8){1'b0}}, instr[7:0]};
    end
endmodule

// File: rtl/psr_lane_merge.sv
// Module: byte-lane merge of a new value into an old value under a lane enable.
// Assumes DATA_W is a whole number of bytes.
module psr_lane_merge #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANES  = DATA_W / 8
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] new_val,
    input  logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Each lane takes the new byte only when its enable is set.
        always_comb merged[g*8 +: 8] = lane_en[g] ? new_val[g*8 +: 8] : old_val[g*8 +: 8];
    end
endmodule

// File: rtl/psr_cpsr_guard.sv
// Module: applies privilege and mode-legality rules to a CPSR write.
// Assumes the mode field sits in [4:0], the endianness bit at E_BIT and the
// flag byte in the top lane.
module psr_cpsr_guard #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANES  = DATA_W / 8
) (
    input  logic [DATA_W-1:0]           cpsr_old,
    input  logic [DATA_W-1:0]           new_val,
    input  logic [LANES-1:0]            lane_mask,
    input  logic [psr_pkg::MODE_W-1:0]  cur_mode,
    output logic [DATA_W-1:0]           cpsr_next,
    output logic                        mode_bad
);
    localparam int unsigned MW = psr_pkg::MODE_W;

    logic              priv;
    logic [LANES-1:0]  eff_en;
    logic [DATA_W-1:0] lanes_out;

    // Effective lane enables: user mode may touch only the top lane.
    always_comb begin
        priv   = (cur_mode != psr_pkg::MODE_USR);
        eff_en = priv ? lane_mask : {lane_mask[LANES-1], {(LANES-1){1'b0}}};
    end

    psr_lane_merge #(.DATA_W(DATA_W), .LANES(LANES)) u_merge (
        .old_val (cpsr_old),
        .new_val (new_val),
        .lane_en (eff_en),
        .merged  (lanes_out)
    );

    // Final value: endianness override for user mode, then mode legality.
    always_comb begin
        cpsr_next = lanes_out;
        if (!priv && lane_mask[psr_pkg::E_BIT / 8])
            cpsr_next[psr_pkg::E_BIT] = new_val[psr_pkg::E_BIT];
        mode_bad = eff_en[0] && !psr_pkg::mode_legal(new_val[MW-1:0]);
        if (mode_bad)
            cpsr_next[MW-1:0] = cpsr_old[MW-1:0];
    end
endmodule

// File: rtl/psr_write_unit.sv
// Module: top of the status register write unit. Holds CPSR and SPSR, decodes
// the instruction word and commits guarded writes on the rising edge.
// Assumes cur_mode is the pipeline's authoritative privilege view.
module psr_write_unit #(
    parameter int unsigned DATA_W    = 32,
    parameter logic [31:0] CPSR_RST  = 32'h0000_0013
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [31:0]                instr_word,
    input  logic                       cond_ok,
    input  logic [DATA_W-1:0]          src_val,
    input  logic [psr_pkg::MODE_W-1:0] cur_mode,
    output logic [DATA_W-1:0]          cpsr_q,
    output logic [DATA_W-1:0]          spsr_q,
    output logic                       unpred_o,
    output logic                       illegal_mode_o
);
    localparam int unsigned LANES = DATA_W / 8;

    psr_pkg::form_e    form;
    logic              to_spsr;
    logic [LANES-1:0]  lane_mask;
    logic [DATA_W-1:0] imm_val;
    logic [DATA_W-1:0] wr_val;
    logic              do_write;
    logic              spsr_blocked;
    logic [DATA_W-1:0] spsr_next;
    logic [DATA_W-1:0] cpsr_next;
    logic              mode_bad;

    psr_decode #(.DATA_W(DATA_W), .LANES(LANES)) u_dec (
        .instr     (instr_word),
        .form      (form),
        .to_spsr   (to_spsr),
        .lane_mask (lane_mask),
        .imm_val   (imm_val)
    );

    // Source pick and write qualification.
    always_comb begin
        wr_val       = (form == psr_pkg::FORM_IMM) ? imm_val : src_val;
        do_write     = cond_ok && ((form == psr_pkg::FORM_REG) || (form == psr_pkg::FORM_IMM));
        spsr_blocked = (cur_mode == psr_pkg::MODE_USR) || (cur_mode == psr_pkg::MODE_SYS);
    end

    psr_lane_merge #(.DATA_W(DATA_W), .LANES(LANES)) u_spsr_merge (
        .old_val (spsr_q),
        .new_val (wr_val),
        .lane_en (lane_mask),
        .merged  (spsr_next)
    );

    psr_cpsr_guard #(.DATA_W(DATA_W), .LANES(LANES)) u_guard (
        .cpsr_old  (cpsr_q),
        .new_val   (wr_val),
        .lane_mask (lane_mask),
        .cur_mode  (cur_mode),
        .cpsr_next (cpsr_next),
        .mode_bad  (mode_bad)
    );

    // State update: commit the chosen register and pulse rejection flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpsr_q         <= CPSR_RST[DATA_W-1:0];
            spsr_q         <= '0;
            unpred_o       <= 1'b0;
            illegal_mode_o <= 1'b0;
        end else begin
            unpred_o       <= 1'b0;
            illegal_mode_o <= 1'b0;
            if (do_write) begin
                if (to_spsr) begin
                    if (spsr_blocked) unpred_o <= 1'b1;
                    else              spsr_q   <= spsr_next;
                end else begin
                    cpsr_q         <= cpsr_next;
                    illegal_mode_o <= mode_bad;
                end
            end
        end
    end
endmodule

// File: rtl/psr_write_chk.sv
// Module: property checker for psr_write_unit, attached by bind below.
// Assumes the default 32-bit width.
module psr_write_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cond_ok,
    input logic [4:0]  cur_mode,
    input logic [31:0] cpsr_q,
    input logic [31:0] spsr_q,
    input logic        unpred_o,
    input logic        illegal_mode_o
);
    // R6: a failed condition leaves all state and flags quiet.
    p_cond_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_ok |=> ($stable(cpsr_q) && $stable(spsr_q) && !unpred_o && !illegal_mode_o));

    // R7: a rejected saved-register write never alters SPSR.
    p_spsr_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        unpred_o |-> $stable(spsr_q));

    // R8: the committed mode is always a legal one.
    p_mode_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        psr_pkg::mode_legal(cpsr_q[4:0]));

    // R8: an illegal-mode rejection keeps the old mode bits.
    p_keep_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_mode_o |-> $stable(cpsr_q[4:0]));

    // R9: user mode protects every CPSR bit below the flag byte except E.
    p_user_protect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == psr_pkg::MODE_USR) |=>
            (cpsr_q[8:0] == $past(cpsr_q[8:0]) && cpsr_q[23:10] == $past(cpsr_q[23:10])));

    // R11: one instruction cannot raise both flags.
    p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(unpred_o && illegal_mode_o));
endmodule

bind psr_write_unit psr_write_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cond_ok        (cond_ok),
    .cur_mode       (cur_mode),
    .cpsr_q         (cpsr_q),
    .spsr_q         (spsr_q),
    .unpred_o       (unpred_o),
    .illegal_mode_o (illegal_mode_o)
);

// File: tb/tb_psr_write_unit.sv
module tb_psr_write_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_word = 32'h0;
    logic        cond_ok = 1'b0;
    logic [31:0] src_val = 32'h0;
    logic [4:0]  cur_mode = 5'b10011;
    logic [31:0] cpsr_q;
    logic [31:0] spsr_q;
    logic        unpred_o;
    logic        illegal_mode_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    psr_write_unit dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .instr_word     (instr_word),
        .cond_ok        (cond_ok),
        .src_val        (src_val),
        .cur_mode       (cur_mode),
        .cpsr_q         (cpsr_q),
        .spsr_q         (spsr_q),
        .unpred_o       (unpred_o),
        .illegal_mode_o (illegal_mode_o)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic [31:0] word;
        logic        cnd;
        logic [31:0] src;
        logic [4:0]  mode;
        logic [31:0] x_cpsr;
        logic [31:0] x_spsr;
        logic        x_unp;
        logic        x_ill;
    } vec_t;

    localparam int NV = 16;
    // Vectors run in order; each expectation includes the effect of earlier ones.
    localparam vec_t VEC [NV] = '{
        '{"R1 ", 32'hE12FF000, 1'b1, 32'h600002D2, 5'b10011, 32'h600002D2, 32'h00000000, 1'b0, 1'b0},
        '{"R4 ", 32'hE128F000, 1'b1, 32'h12345678, 5'b10010, 32'h120002D2, 32'h00000000, 1'b0, 1'b0},
        '{"R3 ", 32'hE163F000, 1'b1, 32'hAABBCCDD, 5'b10010, 32'h120002D2, 32'h0000CCDD, 1'b0, 1'b0},
        '{"R2 ", 32'hE321F4D1, 1'b1, 32'hFFFFFFFF, 5'b10011, 32'h120002D1, 32'h0000CCDD, 1'b0, 1'b0},
        '{"R2 ", 32'hE361F037, 1'b1, 32'hFFFFFFFF, 5'b10011, 32'h120002D1, 32'h0000CC37, 1'b0, 1'b0},
        '{"R5 ", 32'hE121F201, 1'b1, 32'hFFFFFFFF, 5'b10011, 32'h120002D1, 32'h0000CC37, 1'b0, 1'b0},
        '{"R6 ", 32'hE12FF000, 1'b0, 32'h00000000, 5'b10011, 32'h120002D1, 32'h0000CC37, 1'b0, 1'b0},
        '{"R7 ", 32'hE16FF000, 1'b1, 32'h11111111, 5'b10000, 32'h120002D1, 32'h0000CC37, 1'b1, 1'b0},
        '{"R7 ", 32'hE16FF000, 1'b1, 32'h11111111, 5'b11111, 32'h120002D1, 32'h0000CC37, 1'b1, 1'b0},
        '{"R9 ", 32'hE12FF000, 1'b1, 32'hA5FFFD00, 5'b10000, 32'hA50000D1, 32'h0000CC37, 1'b0, 1'b0},
        '{"R8 ", 32'hE129F000, 1'b1, 32'h4C0000F5, 5'b10111, 32'h4C0000F1, 32'h0000CC37, 1'b0, 1'b1},
        '{"R5 ", 32'hE1A00000, 1'b1, 32'hFFFFFFFF, 5'b10011, 32'h4C0000F1, 32'h0000CC37, 1'b0, 1'b0},
        '{"R9 ", 32'hE321F01F, 1'b1, 32'h00000000, 5'b10000, 32'h4C0000F1, 32'h0000CC37, 1'b0, 1'b0},
        '{"R8 ", 32'hE121F000, 1'b1, 32'h0000001F, 5'b11011, 32'h4C00001F, 32'h0000CC37, 1'b0, 1'b0},
        '{"R7 ", 32'hE168F000, 1'b1, 32'h80000000, 5'b10001, 32'h4C00001F, 32'h8000CC37, 1'b0, 1'b0},
        '{"R9 ", 32'hE122F000, 1'b1, 32'h00000200, 5'b10000, 32'h4C00021F, 32'h8000CC37, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [31:0] xc, input logic [31:0] xs,
                             input logic xu, input logic xi);
        chk(req, "cpsr", cpsr_q, xc);
        chk(req, "spsr", spsr_q, xs);
        chk(req, "unpred", {31'b0, unpred_o}, {31'b0, xu});
        chk(req, "illegal", {31'b0, illegal_mode_o}, {31'b0, xi});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_all("R10", 32'h00000013, 32'h0, 1'b0, 1'b0);   // R10 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            instr_word = VEC[i].word;
            cond_ok    = VEC[i].cnd;
            src_val    = VEC[i].src;
            cur_mode   = VEC[i].mode;
            @(posedge clk);
            @(negedge clk);
            check_all($sformatf("%s", VEC[i].tag), VEC[i].x_cpsr, VEC[i].x_spsr,
                      VEC[i].x_unp, VEC[i].x_ill);
        end

        // R11: raise unpred, then a quiet cycle must clear it.
        instr_word = 32'hE16FF000; cond_ok = 1'b1; cur_mode = 5'b10000; src_val = 32'h0;
        @(posedge clk); @(negedge clk);
        chk("R11", "unpred raised", {31'b0, unpred_o}, 32'h1);
        cond_ok = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R11", "unpred cleared", {31'b0, unpred_o}, 32'h0);

        // R8 with R11: illegal mode raises the flag once, then it clears.
        instr_word = 32'hE121F000; cond_ok = 1'b1; cur_mode = 5'b10011; src_val = 32'h00000000;
        @(posedge clk); @(negedge clk);
        chk("R8", "illegal raised", {31'b0, illegal_mode_o}, 32'h1);
        chk("R8", "mode kept", {27'b0, cpsr_q[4:0]}, 32'h1F);
        instr_word = 32'hE1A00000;
        @(posedge clk); @(negedge clk);
        chk("R11", "illegal cleared", {31'b0, illegal_mode_o}, 32'h0);

        // R10: reset overrides a concurrent valid write.
        instr_word = 32'hE12FF000; cond_ok = 1'b1; cur_mode = 5'b10011; src_val = 32'hFFFFFFD2;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check_all("R10", 32'h00000013, 32'h0, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule